// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupt requests for a small processor core. It gathers a non-maskable reset request, a few external request pins (active low) and several internal peripheral request lines. It gates each maskable request with its mask bit and offers the core the highest-priority request that may be taken, together with the address of that request's vector. Vector slots are four instruction words apart. Each external pin can be set to level or falling-edge sensitivity through a control word.

The block keeps a register of the service routines now running. The core takes the offered request with `ack`, which marks that level active. The core ends a routine with `rti`, which clears the highest-priority active level. A control bit selects one of two modes. In nested mode a request may preempt running routines if it outranks all of them. In sequential mode no maskable request is offered while any routine is active.

Source indices fix both the priority and the vector slot. Index 0 is the reset request. Indices 1 to N_EXT are the external pins in pin order. The internal lines follow in their bit order. A lower index means a higher priority.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `irq_valid` is 0 and `active_lvl` is all zeros.
- R2: Source index s ≥ 1 is offered only if `irq_mask[s-1]` is 1. A masked request produces no offer.
- R3: Source 0 (`reset_req`) ignores the mask and outranks every other source. It is offered in both modes unless level 0 is already active.
- R4: When several sources are eligible at once, the one with the lowest index is offered.
- R5: When `irq_ctrl[4]` is 0 (sequential), no source other than 0 is offered while `active_lvl` is nonzero.
- R6: When `irq_ctrl[4]` is 1 (nested), a source is offered only if its index is lower than every set bit of `active_lvl`.
- R7: `irq_vector` equals VEC_BASE + 4 × `irq_src`.
- R8: If `irq_ctrl[i]` is 1, external pin i is edge-sensitive. A high-to-low transition latches a pending request, which stays after the pin rises and is cleared when that source is acknowledged. A new falling edge in the acknowledge cycle latches again.
- R9: If `irq_ctrl[i]` is 0, external pin i is level-sensitive. It is requested only while the pin is low, and nothing is latched.
- R10: `ack` while `irq_valid` is 1 sets bit `irq_src` of `active_lvl` at the next edge.
- R11: `rti` clears the lowest-index set bit of `active_lvl` at the next edge.
- R12: Outputs are registered. A request applied before clock edge k is first seen on `irq_valid` just after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_n | input | N_EXT | External request pins, active low |
| int_req | input | N_INT | Internal peripheral requests, active high, level |
| reset_req | input | 1 | Non-maskable top-priority request (source 0) |
| irq_mask | input | N_SRC-1 | Bit s-1 enables source s |
| irq_ctrl | input | 5 | Bits [N_EXT-1:0]: edge select per pin; bit 4: nested mode |
| ack | input | 1 | Core takes the offered request |
| rti | input | 1 | Core returns from the current routine |
| irq_valid | output | 1 | A request is offered |
| irq_vector | output | ADDR_W | Vector address of the offered source |
| irq_src | output | IDX_W | Index of the offered source |
| active_lvl | output | N_SRC | Routines in service, one bit per source |

## Verification
A new falling edge on an edge-sensitive pin can arrive in the same cycle in which the core acknowledges that pin's earlier request. The two then compete for the one pending bit. The bench provokes this by dropping the pin again in the cycle `ack` is high, while the routine just taken blocks the source. It then issues `rti` and expects the source to be offered again, which shows that the new edge won over the clear. A second overlap, `rti` and a pin release in one edge, is checked through `active_lvl` and the next offer.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned CTRL_W     = 5;
  localparam int unsigned NEST_BIT   = 4;
  localparam int unsigned VEC_STRIDE = 4;
endpackage

// File: rtl/irqc_ext_capture.sv
module irqc_ext_capture #(
  parameter int unsigned N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] pin_n,
  input  logic [N_EXT-1:0] edge_mode,
  input  logic [N_EXT-1:0] ack_hit,
  output logic [N_EXT-1:0] req
);
  logic [N_EXT-1:0] pin_prev;
  logic [N_EXT-1:0] pend_q;
  logic [N_EXT-1:0] pend_d;
  logic [N_EXT-1:0] fall;

  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    assign fall[i]   = pin_prev[i] & ~pin_n[i];
    // a fresh edge beats the clear from an acknowledge in the same cycle
    assign pend_d[i] = edge_mode[i] ? (fall[i] | (pend_q[i] & ~ack_hit[i])) : 1'b0;
    assign req[i]    = edge_mode[i] ? pend_d[i] : ~pin_n[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev <= '1;
      pend_q   <= '0;
    end else begin
      pin_prev <= pin_n;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/irqc_active_track.sv
module irqc_active_track #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] ack_hit,
  input  logic             rti,
  output logic [N_SRC-1:0] act_q,
  output logic [N_SRC-1:0] act_next
);
  logic [N_SRC-1:0] lowest;

  // isolate the highest-priority (lowest-index) active level
  assign lowest   = act_q & (~act_q + N_SRC'(1));
  assign act_next = (act_q & ~(rti ? lowest : '0)) | ack_hit;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_next;
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] act,
  input  logic             nest,
  output logic             grant_valid,
  output logic [IDX_W-1:0] grant_idx
);
  logic [N_SRC-1:0] blocked;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] cand;
  logic             idle;

  assign idle = (act == '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    if (i == 0) begin : g_top
      assign blocked[i] = act[i];
      assign elig[i]    = ~act[i];
    end else begin : g_rest
      assign blocked[i] = blocked[i-1] | act[i];
      assign elig[i]    = nest ? ~blocked[i] : idle;
    end
  end

  assign cand = req & elig;

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant_valid = 1'b1;
        grant_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_EXT    = 3,
  parameter int unsigned N_INT    = 4,
  parameter int unsigned ADDR_W   = 14,
  parameter logic [ADDR_W-1:0] VEC_BASE = 14'h040,
  localparam int unsigned N_SRC   = 1 + N_EXT + N_INT,
  localparam int unsigned IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_irq_n,
  input  logic [N_INT-1:0]  int_req,
  input  logic              reset_req,
  input  logic [N_SRC-2:0]  irq_mask,
  input  logic [CTRL_W-1:0] irq_ctrl,
  input  logic              ack,
  input  logic              rti,
  output logic              irq_valid,
  output logic [ADDR_W-1:0] irq_vector,
  output logic [IDX_W-1:0]  irq_src,
  output logic [N_SRC-1:0]  active_lvl
);
  logic [N_SRC-1:0] ack_hit;
  logic [N_EXT-1:0] ext_req;
  logic [N_SRC-1:0] raw_req;
  logic [N_SRC-1:0] gated_req;
  logic [N_SRC-1:0] act_next;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;

  always_comb begin
    ack_hit = '0;
    if (ack && irq_valid) ack_hit[irq_src] = 1'b1;
  end

  irqc_ext_capture #(.N_EXT(N_EXT)) u_ext (
    .clk       (clk),
    .rst       (rst),
    .pin_n     (ext_irq_n),
    .edge_mode (irq_ctrl[N_EXT-1:0]),
    .ack_hit   (ack_hit[N_EXT:1]),
    .req       (ext_req)
  );

  irqc_active_track #(.N_SRC(N_SRC)) u_act (
    .clk      (clk),
    .rst      (rst),
    .ack_hit  (ack_hit),
    .rti      (rti),
    .act_q    (active_lvl),
    .act_next (act_next)
  );

  assign raw_req   = {int_req, ext_req, reset_req};
  assign gated_req = raw_req & {irq_mask, 1'b1};

  irqc_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .req         (gated_req),
    .act         (act_next),
    .nest        (irq_ctrl[NEST_BIT]),
    .grant_valid (win_valid),
    .grant_idx   (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_src    <= '0;
      irq_vector <= VEC_BASE;
    end else begin
      irq_valid  <= win_valid;
      irq_src    <= win_idx;
      irq_vector <= VEC_BASE + ADDR_W'(ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE));
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-2:0] irq_mask,
  input logic [4:0]       irq_ctrl,
  input logic             reset_req,
  input logic             ack,
  input logic             irq_valid,
  input logic [IDX_W-1:0] irq_src,
  input logic [N_SRC-1:0] active_lvl
);
  logic [N_SRC-2:0] mask_d;
  logic             nest_d;
  logic             rr_d;
  logic             took_d;
  logic [IDX_W-1:0] took_src_d;
  logic [N_SRC-1:0] upto;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d     <= '0;
      nest_d     <= 1'b0;
      rr_d       <= 1'b0;
      took_d     <= 1'b0;
      took_src_d <= '0;
    end else begin
      mask_d     <= irq_mask;
      nest_d     <= irq_ctrl[4];
      rr_d       <= reset_req && !active_lvl[0] && !(ack && irq_valid && irq_src == '0);
      took_d     <= ack && irq_valid;
      took_src_d <= irq_src;
    end
  end

  always_comb begin
    for (int i = 0; i < N_SRC; i++) upto[i] = (i <= int'(irq_src));
  end

  p_mask_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src != '0) |-> mask_d[int'(irq_src) - 1]);

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (rst)
    rr_d |-> (irq_valid && irq_src == '0));

  p_seq_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src != '0 && !nest_d) |-> (active_lvl == '0));

  p_nest_outranks_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && nest_d) |-> ((active_lvl & upto) == '0));

  p_ack_marks_r10: assert property (@(posedge clk) disable iff (rst)
    took_d |-> active_lvl[took_src_d]);
endmodule

bind irq_vector_ctrl irqc_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .irq_mask   (irq_mask),
  .irq_ctrl   (irq_ctrl),
  .reset_req  (reset_req),
  .ack        (ack),
  .irq_valid  (irq_valid),
  .irq_src    (irq_src),
  .active_lvl (active_lvl)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
  localparam int N_EXT = 3;
  localparam int N_INT = 4;
  localparam int N_SRC = 1 + N_EXT + N_INT;
  localparam int IDX_W = $clog2(N_SRC);
  localparam int ADDR_W = 14;
  localparam int VBASE = 'h40;

  logic              clk = 1'b0;
  logic              rst;
  logic [N_EXT-1:0]  ext_irq_n;
  logic [N_INT-1:0]  int_req;
  logic              reset_req;
  logic [N_SRC-2:0]  irq_mask;
  logic [4:0]        irq_ctrl;
  logic              ack;
  logic              rti;
  logic              irq_valid;
  logic [ADDR_W-1:0] irq_vector;
  logic [IDX_W-1:0]  irq_src;
  logic [N_SRC-1:0]  active_lvl;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl #(.N_EXT(N_EXT), .N_INT(N_INT), .ADDR_W(ADDR_W),
                    .VEC_BASE(14'h040)) dut_i (
    .clk(clk), .rst(rst), .ext_irq_n(ext_irq_n), .int_req(int_req),
    .reset_req(reset_req), .irq_mask(irq_mask), .irq_ctrl(irq_ctrl),
    .ack(ack), .rti(rti), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_src(irq_src), .active_lvl(active_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_offer(input bit v, input int s, input string tag);
    chk(irq_valid === v, {tag, " valid"}, int'(irq_valid), int'(v));
    if (v) begin
      chk(int'(irq_src) == s, {tag, " src"}, int'(irq_src), s);
      chk(int'(irq_vector) == VBASE + 4 * s, {tag, " R7 vector"}, int'(irq_vector), VBASE + 4 * s);
    end
  endtask

  task automatic expect_active(input int exp, input string tag);
    chk(int'(active_lvl) == exp, {tag, " active"}, int'(active_lvl), exp);
  endtask

  task automatic pulse_ack;
    ack = 1'b1; tick; ack = 1'b0;
  endtask

  task automatic pulse_rti;
    rti = 1'b1; tick; rti = 1'b0;
  endtask

  task automatic do_reset;
    ext_irq_n = '1; int_req = '0; reset_req = 1'b0; irq_mask = '1;
    irq_ctrl = 5'b10000; ack = 1'b0; rti = 1'b0;
    rst = 1'b1;
    repeat (3) tick;
    expect_offer(1'b0, 0, "R1 in reset");
    rst = 1'b0;
    tick;
  endtask

  task automatic t_reset_state;
    do_reset();
    expect_offer(1'b0, 0, "R1 after reset");
    expect_active(0, "R1 after reset");
  endtask

  task automatic t_level;
    do_reset();
    ext_irq_n[1] = 1'b0;
    #1 expect_offer(1'b0, 0, "R12 before edge");
    tick; expect_offer(1'b1, 2, "R12 R9 level low");
    tick; expect_offer(1'b1, 2, "R9 level held");
    ext_irq_n[1] = 1'b1;
    tick; expect_offer(1'b0, 0, "R9 not latched");
  endtask

  task automatic t_edge;
    do_reset();
    irq_ctrl = 5'b10001;
    ext_irq_n[0] = 1'b0; tick; expect_offer(1'b1, 1, "R8 fall");
    ext_irq_n[0] = 1'b1; tick; expect_offer(1'b1, 1, "R8 latched");
    pulse_ack(); expect_active('h2, "R10 ack"); expect_offer(1'b0, 0, "R8 taken");
    pulse_rti(); expect_active(0, "R11 rti"); expect_offer(1'b0, 0, "R8 cleared by ack");
    ext_irq_n[0] = 1'b0; tick;
    ext_irq_n[0] = 1'b1; tick; expect_offer(1'b1, 1, "R8 second edge");
    ext_irq_n[0] = 1'b0; ack = 1'b1; tick; ack = 1'b0;
    ext_irq_n[0] = 1'b1;
    expect_active('h2, "R10 ack with edge"); expect_offer(1'b0, 0, "R8 blocked while active");
    pulse_rti(); expect_offer(1'b1, 1, "R8 edge in ack cycle relatched");
    pulse_ack(); pulse_rti(); expect_offer(1'b0, 0, "R8 drained");
  endtask

  task automatic t_mask;
    do_reset();
    irq_mask = 7'b1110111;
    int_req[0] = 1'b1; tick; expect_offer(1'b0, 0, "R2 masked");
    tick; expect_offer(1'b0, 0, "R2 still masked");
    irq_mask = '1; tick; expect_offer(1'b1, 4, "R2 unmasked");
    int_req[0] = 1'b0; tick; expect_offer(1'b0, 0, "R2 released");
  endtask

  task automatic t_priority;
    do_reset();
    int_req[3] = 1'b1; ext_irq_n[2] = 1'b0;
    tick; expect_offer(1'b1, 3, "R4 lower index wins");
    ext_irq_n[2] = 1'b1; tick; expect_offer(1'b1, 7, "R4 next in line");
    int_req = '0; tick; expect_offer(1'b0, 0, "R4 idle");
  endtask

  task automatic t_reset_src;
    do_reset();
    irq_mask = '0; int_req = '1; ext_irq_n = '0; reset_req = 1'b1;
    tick; expect_offer(1'b1, 0, "R3 unmaskable top");
    reset_req = 1'b0; tick; expect_offer(1'b0, 0, "R2 all masked");
    int_req = '0; ext_irq_n = '1; irq_mask = '1;
  endtask

  task automatic t_nested;
    do_reset();
    int_req[3] = 1'b1; tick; expect_offer(1'b1, 7, "R6 idle offer");
    pulse_ack(); expect_active('h80, "R10 low level"); expect_offer(1'b0, 0, "R6 no self preempt");
    ext_irq_n[0] = 1'b0; tick; expect_offer(1'b1, 1, "R6 preempt");
    pulse_ack(); expect_active('h82, "R10 nested"); expect_offer(1'b0, 0, "R6 both blocked");
    ext_irq_n[0] = 1'b1;
    pulse_rti(); expect_active('h80, "R11 lowest index cleared"); expect_offer(1'b0, 0, "R6 outer still active");
    pulse_rti(); expect_active(0, "R11 all clear"); expect_offer(1'b1, 7, "R6 reoffer");
    int_req = '0; tick; expect_offer(1'b0, 0, "R6 idle");
  endtask

  task automatic t_seq;
    do_reset();
    irq_ctrl = 5'b00000;
    int_req[3] = 1'b1; tick; expect_offer(1'b1, 7, "R5 idle offer");
    pulse_ack(); int_req[3] = 1'b0; expect_active('h80, "R10 seq");
    ext_irq_n[0] = 1'b0; tick; expect_offer(1'b0, 0, "R5 higher held off");
    tick; expect_offer(1'b0, 0, "R5 still held off");
    reset_req = 1'b1; tick; expect_offer(1'b1, 0, "R3 reset bypasses sequential");
    reset_req = 1'b0; rti = 1'b1; tick; rti = 1'b0;
    expect_active(0, "R11 seq rti"); expect_offer(1'b1, 1, "R5 offered after rti");
    ext_irq_n[0] = 1'b1; tick; expect_offer(1'b0, 0, "R5 idle");
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_level();
    t_edge();
    t_mask();
    t_priority();
    t_reset_src();
    t_nested();
    t_seq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule